// File: doc/BRIEF.md
# Miller-Coded ROM Readout Transmitter

This block is the digital core of a passive read-only tag. A chain of toggle stages counts the clock recovered from the carrier and produces a half-bit strobe and a bit strobe at one of seven power-of-two ratios. A framer steps through a fixed 64-bit word. Each time round, it wraps the word in a quiet interval, a start bit and a stop bit. An encoder turns that serial stream into Miller code on a single modulator-switch output.

The frame repeats with no gap for as long as the clock runs. The quiet interval holds the switch off. The off time seen at the antenna therefore depends on whether the stop bit left the switch on or off, and on the half period of off time that begins every start bit. The word is an input port so that the integration can tie it to constants. It must be held stable while the block runs.

Top module: `miller_tag_tx`

## Requirements
- R1: While `rst_n` is low at a rising edge, `mod_on` goes to 0, the divider clears, and the frame restarts at its first pause bit.
- R2: One bit period lasts 128 << `rate_sel` clock cycles for `rate_sel` codes 0 to 6, which gives 128, 256, 512, 1024, 2048, 4096 and 8192. Code 7 gives the standard ratio of 512. Each half-bit lasts half the bit period.
- R3: Each frame opens with PAUSE_BITS bit periods (default 2) during which `mod_on` is 0.
- R4: The start bit (value 1) follows the pause. `mod_on` is 0 for its first half and 1 for its second half.
- R5: The data bits follow the start bit in the order `rom_word[63]` first, down to `rom_word[0]` last.
- R6: A bit of value 1 toggles `mod_on` at mid-bit and leaves it unchanged at the start of the bit.
- R7: A bit of value 0 never toggles at mid-bit. It toggles `mod_on` at the start of the bit only when the previous bit was also 0.
- R8: A stop bit of value 0 follows the last data bit under the rule of R7. At the end of the stop bit, `mod_on` is forced to 0 for the next pause, whatever its level was.
- R9: Frames follow one another without end or gap, and every frame carries the same waveform.
- R10: `mod_on` changes only at half-bit boundaries. After reset is released, the first possible change is at clock edge N/2, where N is the bit period in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock recovered from the carrier |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 3 | Code that selects the division ratio (see R2) |
| rom_word | input | 64 | Read-only word to transmit, held stable |
| mod_on | output | 1 | Modulator switch drive, 1 = switch on |

## Verification
At the end of a stop bit, two rules fall in the same clock edge: the Miller boundary rule, which would toggle the level after a trailing 0, and the forced-off entry into the pause. This edge is provoked with words whose last bit is 0 after a 1, 0 after a 0, and 1. The stop bit therefore ends with the switch on in some cases and off in others. A scoreboard built from R3 to R8 samples every half-bit, from reset through more than one frame. It checks that the first pause half is low in every case, so the clash never leaks into the pause. A second pair of coincidences is the mid-bit toggle and the bit boundary, which share the same divider carry. These are judged at the exact edges around the first rise of the start bit, for every ratio code.

// File: rtl/mtx_pkg.sv
// Package mtx_pkg
// Shared constants and types for the Miller-coded ROM transmitter.
// Assumes power-of-two division ratios, starting at 2**MIN_LOG2.
package mtx_pkg;

    localparam int MIN_LOG2  = 7;   // smallest ratio: 128
    localparam int NUM_RATES = 7;   // 128 .. 8192
    localparam int SEL_W     = 3;   // width of the ratio select code
    localparam int DEF_SEL   = 2;   // code used for out-of-range selects (512)

    // Which part of the frame a bit position belongs to.
    typedef enum logic [1:0] {
        SEG_PAUSE = 2'd0,
        SEG_START = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_STOP  = 2'd3
    } seg_t;

    // One bit slot of the frame: its segment and its NRZ value.
    typedef struct packed {
        seg_t seg;
        logic val;
    } slot_t;

endpackage

// File: rtl/mtx_divider.sv
// Module mtx_divider
// Ripple-style chain of toggle stages counting the carrier clock.
// The carry into stage k marks the end of every 2**k cycles. For the
// selected ratio 2**L, the carry into stage L-1 is the half-bit strobe
// and the carry into stage L is the bit strobe.
// Assumes rate_sel is stable while out of reset.
module mtx_divider #(
    parameter int MIN_LOG2  = 7,
    parameter int NUM_RATES = 7,
    parameter int SEL_W     = 3,
    parameter int DEF_SEL   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             half_end,
    output logic             bit_end
);

    localparam int STAGES = MIN_LOG2 + NUM_RATES - 1;
    localparam int SLOTS  = 1 << SEL_W;

    logic [STAGES-1:0] q;
    logic [STAGES:0]   carry;
    logic [SLOTS-1:0]  half_v;
    logic [SLOTS-1:0]  bit_v;

    assign carry[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            assign carry[gi+1] = carry[gi] & q[gi];

            // Toggle this stage whenever all lower stages are at one.
            always_ff @(posedge clk) begin
                if (!rst_n)         q[gi] <= 1'b0;
                else if (carry[gi]) q[gi] <= ~q[gi];
            end
        end

        for (gi = 0; gi < SLOTS; gi++) begin : g_rate
            localparam int EFF = (gi < NUM_RATES) ? gi : DEF_SEL;
            localparam int L   = MIN_LOG2 + EFF;
            assign half_v[gi] = carry[L-1];
            assign bit_v[gi]  = carry[L];
        end
    endgenerate

    // Pick the strobe pair of the selected ratio.
    always_comb begin
        half_end = half_v[rate_sel];
        bit_end  = bit_v[rate_sel];
    end

endmodule

// File: rtl/mtx_framer.sv
// Module mtx_framer
// Steps a bit position through pause, start, data (MSB first) and stop,
// then wraps to the pause. It presents the current slot and the slot
// that follows, so that the encoder can apply its boundary rule.
// Assumes PAUSE_BITS >= 1 and rom_word stable.
module mtx_framer
    import mtx_pkg::*;
#(
    parameter int WORD_W     = 64,
    parameter int PAUSE_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic [WORD_W-1:0] rom_word,
    output slot_t             cur_slot,
    output slot_t             nxt_slot
);

    localparam int TOTAL = PAUSE_BITS + WORD_W + 2;
    localparam int POS_W = $clog2(TOTAL);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    localparam logic [POS_W-1:0] START_POS = POS_W'(PAUSE_BITS);
    localparam logic [POS_W-1:0] STOP_POS  = POS_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(WORD_W - 1);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_nxt;

    // Map a frame position to its segment and NRZ value.
    function automatic slot_t decode(input logic [POS_W-1:0] p,
                                     input logic [WORD_W-1:0] w);
        slot_t            s;
        logic [IDX_W-1:0] didx;
        didx = TOP_IDX - IDX_W'(p - START_POS - 1'b1);
        if (p < START_POS) begin
            s.seg = SEG_PAUSE;
            s.val = 1'b0;
        end else if (p == START_POS) begin
            s.seg = SEG_START;
            s.val = 1'b1;
        end else if (p == STOP_POS) begin
            s.seg = SEG_STOP;
            s.val = 1'b0;
        end else begin
            s.seg = SEG_DATA;
            s.val = w[didx];
        end
        return s;
    endfunction

    // Next position, wrapping after the stop bit.
    always_comb begin
        pos_nxt = (pos == STOP_POS) ? '0 : pos + 1'b1;
    end

    // Advance one position at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos <= '0;
        else if (bit_end) pos <= pos_nxt;
    end

    // Present the current and the following slot.
    always_comb begin
        cur_slot = decode(pos, rom_word);
        nxt_slot = decode(pos_nxt, rom_word);
    end

endmodule

// File: rtl/mtx_miller_enc.sv
// Module mtx_miller_enc
// Holds the modulator level and applies the Miller rules. A 1 toggles at
// mid-bit. A 0 toggles at the start of the bit only after another 0.
// Entering the pause or the start bit forces the level off.
// Assumes bit_end is only ever high together with half_end.
module mtx_miller_enc
    import mtx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  half_end,
    input  logic  bit_end,
    input  slot_t cur_slot,
    input  slot_t nxt_slot,
    output logic  mod_on
);

    logic enter_quiet;
    logic zero_run;

    // Classify the coming boundary.
    always_comb begin
        enter_quiet = (nxt_slot.seg == SEG_PAUSE) || (nxt_slot.seg == SEG_START);
        zero_run    = !nxt_slot.val && !cur_slot.val;
    end

    // Update the switch level at half-bit and bit boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_on <= 1'b0;
        end else if (bit_end) begin
            if (enter_quiet)   mod_on <= 1'b0;
            else if (zero_run) mod_on <= ~mod_on;
        end else if (half_end) begin
            if (cur_slot.seg != SEG_PAUSE && cur_slot.val) mod_on <= ~mod_on;
        end
    end

endmodule

// File: rtl/miller_tag_tx.sv
// Module miller_tag_tx
// Top level of the tag transmitter: divider, framer and Miller encoder.
// Assumes rate_sel and rom_word are held stable out of reset. Reset is
// synchronous and active low.
module miller_tag_tx
    import mtx_pkg::*;
#(
    parameter int WORD_W     = 64,
    parameter int PAUSE_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        rate_sel,
    input  logic [WORD_W-1:0] rom_word,
    output logic              mod_on
);

    logic  half_end;
    logic  bit_end;
    slot_t cur_slot;
    slot_t nxt_slot;

    mtx_divider #(
        .MIN_LOG2  (MIN_LOG2),
        .NUM_RATES (NUM_RATES),
        .SEL_W     (SEL_W),
        .DEF_SEL   (DEF_SEL)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .half_end (half_end),
        .bit_end  (bit_end)
    );

    mtx_framer #(
        .WORD_W     (WORD_W),
        .PAUSE_BITS (PAUSE_BITS)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_end  (bit_end),
        .rom_word (rom_word),
        .cur_slot (cur_slot),
        .nxt_slot (nxt_slot)
    );

    mtx_miller_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_end (half_end),
        .bit_end  (bit_end),
        .cur_slot (cur_slot),
        .nxt_slot (nxt_slot),
        .mod_on   (mod_on)
    );

endmodule

// File: rtl/miller_tag_tx_chk.sv
// Module miller_tag_tx_chk
// Property checker bound into miller_tag_tx. It watches the divider
// strobes, the framer slots and the switch output.
module miller_tag_tx_chk
    import mtx_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  half_end,
    input logic  bit_end,
    input slot_t cur_slot,
    input slot_t nxt_slot,
    input logic  mod_on
);

    // R10: no change away from a half-bit boundary.
    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !half_end |=> $stable(mod_on));

    // R3: the switch is off throughout the pause.
    a_r3_pause_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_slot.seg == SEG_PAUSE) |-> !mod_on);

    // R4: the start bit begins with the switch off.
    a_r4_start_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && nxt_slot.seg == SEG_START) |=> !mod_on);

    // R6: a 1 toggles at mid-bit.
    a_r6_mid_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (half_end && !bit_end && cur_slot.seg != SEG_PAUSE && cur_slot.val)
        |=> (mod_on != $past(mod_on)));

    // R7: a 0 holds at mid-bit.
    a_r7_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (half_end && !bit_end && !cur_slot.val) |=> $stable(mod_on));

    // R7: a 0 after a 0 toggles at the start of a data bit.
    a_r7_edge_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && nxt_slot.seg == SEG_DATA && !nxt_slot.val && !cur_slot.val)
        |=> (mod_on != $past(mod_on)));

    // R8: leaving the stop bit always lands in the pause with the switch off.
    a_r8_stop_to_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && cur_slot.seg == SEG_STOP)
        |=> (cur_slot.seg == SEG_PAUSE && !mod_on));

endmodule

bind miller_tag_tx miller_tag_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_end (half_end),
    .bit_end  (bit_end),
    .cur_slot (cur_slot),
    .nxt_slot (nxt_slot),
    .mod_on   (mod_on)
);

// File: tb/miller_tag_tx_tb.sv
// Bench miller_tag_tx_tb
// Scoreboard bench. A driver task builds the expected half-bit levels of
// whole frames from the requirements and queues them. A monitor process
// samples mod_on in the middle of each half-bit and compares.
module miller_tag_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 64;
    localparam int PAUSE_BITS = 2;
    localparam int WATCHDOG   = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        rate_sel = 3'd0;
    logic [WORD_W-1:0] rom_word = '0;
    logic              mod_on;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    int    mon_half = 64;
    bit    exp_q[$];
    string req_q[$];
    event  mon_go;
    event  mon_done;

    miller_tag_tx #(
        .WORD_W     (WORD_W),
        .PAUSE_BITS (PAUSE_BITS)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .rom_word (rom_word),
        .mod_on   (mod_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one comparison.
    task automatic chk(input bit act, input bit exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: queue the expected half-bit levels of nframes frames (R3..R9).
    task automatic push_frames(input logic [WORD_W-1:0] w, input int nframes);
        bit lvl;
        bit prev;
        bit b;
        for (int f = 0; f < nframes; f++) begin
            string tag9;
            tag9 = (f > 0) ? " R9" : "";
            lvl = 1'b0;
            for (int p = 0; p < 2*PAUSE_BITS; p++) begin
                exp_q.push_back(1'b0); req_q.push_back({"R3", tag9});
            end
            exp_q.push_back(1'b0); req_q.push_back({"R4", tag9});
            exp_q.push_back(1'b1); req_q.push_back({"R4", tag9});
            lvl  = 1'b1;
            prev = 1'b1;
            for (int i = 0; i <= WORD_W; i++) begin
                string tg;
                b  = (i < WORD_W) ? w[WORD_W-1-i] : 1'b0;
                tg = (i == WORD_W) ? "R8" : (b ? "R5 R6" : "R5 R7");
                if (!b && !prev) lvl = ~lvl;
                exp_q.push_back(lvl); req_q.push_back({tg, tag9});
                if (b) lvl = ~lvl;
                exp_q.push_back(lvl); req_q.push_back({tg, tag9});
                prev = b;
            end
        end
        // The half after the last stop bit must be the forced-off pause (R8).
        exp_q.push_back(1'b0); req_q.push_back("R8 R3");
    endtask

    // Monitor: sample mid half-bit and compare against the queue.
    initial begin
        forever begin
            @(mon_go);
            for (int k = 0; exp_q.size() > 0; k++) begin
                bit    e;
                string r;
                repeat ((k == 0) ? mon_half/2 : mon_half) @(posedge clk);
                @(negedge clk);
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(mod_on, e, r, $sformatf("half-bit %0d", k));
            end
            ->mon_done;
        end
    end

    // Reset, load a word and ratio code, and score nframes frames.
    task automatic run_case(input logic [WORD_W-1:0] w, input logic [2:0] code,
                            input int ratio, input int nframes);
        @(negedge clk);
        rst_n    = 1'b0;
        rom_word = w;
        rate_sel = code;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mod_on, 1'b0, "R1", "output in reset");
        mon_half = ratio / 2;
        push_frames(w, nframes);
        rst_n = 1'b1;
        ->mon_go;
        @(mon_done);
    endtask

    // First rise lands exactly at edge (2*PAUSE_BITS+1)*ratio/2 (R2, R4, R10).
    task automatic check_ratio(input logic [2:0] code, input int ratio);
        int h;
        h = ratio / 2;
        @(negedge clk);
        rst_n    = 1'b0;
        rate_sel = code;
        rom_word = 64'hFFFF_0000_FFFF_0000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat ((2*PAUSE_BITS+1)*h - 1) @(posedge clk);
        @(negedge clk);
        chk(mod_on, 1'b0, "R2 R10", $sformatf("code %0d before start mid-bit", code));
        @(posedge clk);
        @(negedge clk);
        chk(mod_on, 1'b1, "R2 R4", $sformatf("code %0d at start mid-bit", code));
    endtask

    // Print the one summary line and end the run.
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mod_on, 1'b0, "R1", "output after power-up reset");

        // Frames: the word ends in 1, then all zeros, then a 0 after ones.
        run_case(64'hA5F0_0F3C_9612_7E81, 3'd0, 128, 2);
        run_case(64'h0000_0000_0000_0000, 3'd1, 256, 2);
        run_case(64'hFFFF_FFFF_FFFF_FFFE, 3'd0, 128, 2);

        // R1: reset in mid-frame forces the switch off, then a clean restart.
        @(negedge clk);
        rst_n = 1'b1;
        repeat (1000) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(mod_on, 1'b0, "R1", "output after mid-frame reset");
        run_case(64'h8000_0000_0000_0001, 3'd0, 128, 1);

        // R2: every ratio code, including the out-of-range one.
        for (int c = 0; c < 7; c++) check_ratio(3'(c), 128 << c);
        check_ratio(3'd7, 512);

        finish_run();
    end

endmodule